// File: doc/BRIEF.md
# Page Reference and Modify Bit Tracker

This block keeps two bit vectors, with one bit for each translation entry. The reference vector records that a mapped page has been touched. The modify vector records that the page has been written. Hardware sets the bits as qualified translated accesses complete. Software in supervisor state reads the vectors and uses them to age pages for least-recently-used replacement and to decide which pages need writing back before eviction.

The lookup side gives the tracker a hit strobe, the index of the hit entry, a write flag, a mapped-user qualifier and a protection-fault flag. The supervisor register bus selects a 4 KiB register page through address bits 19:12, passed in as `busPage`. Each vector is exposed as packed 16-bit words. A word write loads all 16 bits at once. Each vector also has its own clear-all page. Every access to a status page is acknowledged by pulling both acknowledge lines low.

Top module: `pageUseTracker`

## Requirements
- R1: After reset both vectors are all zero, `busAckN` is 2'b11 and `busRData` is zero.
- R2: A cycle with `hitStrobe`=1, `mappedUser`=1 and `protFault`=0 sets reference bit `hitIndex`. Entry i is bit i%16 of the reference word at page 0x80+i/16.
- R3: A qualifying hit as in R2 that also has `hitWrite`=1 sets modify bit `hitIndex`. Entry i is bit i%16 of the modify word at page 0x85+i/16.
- R4: A hit with `mappedUser`=0 or `protFault`=1 changes neither vector. A qualifying hit with `hitWrite`=0 leaves the modify vector unchanged.
- R5: A bus write to pages 0x80..0x83 loads `busWData` into that reference word. A bus write to pages 0x85..0x88 loads `busWData` into that modify word. No other word changes.
- R6: A bus write to page 0x84 clears all reference bits. A bus write to page 0x89 clears all modify bits. The other vector is untouched.
- R7: When a hardware set and a bus word write or clear-all hit the same bit in the same cycle, the bit ends up set.
- R8: A bus read of a word page returns that word on `busRData` in the cycle after the select, with `busAckN`=2'b00 for that one cycle. Reads of the two clear-all pages return zero.
- R9: A select of a page outside 0x80..0x89 gives no acknowledge and does not change the vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitStrobe | input | 1 | A translation hit completes this cycle |
| hitIndex | input | 6 | Index of the hit entry |
| hitWrite | input | 1 | The hit access is a write |
| mappedUser | input | 1 | The access is in mapped user state |
| protFault | input | 1 | The hit violated page protection |
| busSel | input | 1 | Register bus select, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busPage | input | 8 | Register page, address bits 19:12 |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data, valid with the acknowledge |
| busAckN | output | 2 | Active-low acknowledge pair, both low together |

## Verification
The bench walks a hit across all 64 entries in several forms. First it applies hits that must be ignored: hits in unmapped state, hits with a fault, and a mix of the two. It then applies qualifying hits in which only every third entry writes, so the reference and modify maps come out different and a swapped vector or a swapped bit position shows up. After that come walking-one and checkerboard word writes, which catch any mix-up in word order or bit order, and the two clear-all pages, each checked against the vector it must leave alone. Last, the bench makes a hardware set collide with a zeroing word write and with a clear, and it reads the clear pages and an out-of-range page to confirm that these give zero data and no acknowledge where the requirements say so.

// File: rtl/pageUseTrackerPkg.sv
package pageUseTrackerPkg;

  localparam int PAGE_W = 8;
  localparam int SLOT_W = 8;

  typedef struct packed {
    logic              hwAcc;
    logic              hwDir;
    logic              accWr;
    logic              dirWr;
    logic              accClr;
    logic              dirClr;
    logic              rdEn;
    logic              rdDirty;
    logic [SLOT_W-1:0] wordIdx;
  } trackStrobe_t;

endpackage

// File: rtl/pageUseCtrl.sv
module pageUseCtrl
  import pageUseTrackerPkg::*;
#(
  parameter int NWORDS   = 4,
  parameter int ACC_BASE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hitStrobe,
  input  logic              hitWrite,
  input  logic              mappedUser,
  input  logic              protFault,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [PAGE_W-1:0] busPage,
  output trackStrobe_t      st,
  output logic [1:0]        busAckN
);

  localparam logic [PAGE_W-1:0] ACC_LO  = PAGE_W'(ACC_BASE);
  localparam logic [PAGE_W-1:0] ACC_CLR = PAGE_W'(ACC_BASE + NWORDS);
  localparam logic [PAGE_W-1:0] DIR_LO  = PAGE_W'(ACC_BASE + NWORDS + 1);
  localparam logic [PAGE_W-1:0] DIR_CLR = PAGE_W'(ACC_BASE + 2 * NWORDS + 1);

  logic inAcc, inDir, inRange, hitOk, ackQ;

  always_comb begin
    inAcc   = (busPage >= ACC_LO) && (busPage < ACC_CLR);
    inDir   = (busPage >= DIR_LO) && (busPage < DIR_CLR);
    inRange = (busPage >= ACC_LO) && (busPage <= DIR_CLR);
    hitOk   = hitStrobe && mappedUser && !protFault;

    st         = '0;
    st.hwAcc   = hitOk;
    st.hwDir   = hitOk && hitWrite;
    st.accWr   = busSel && busWrite && inAcc;
    st.dirWr   = busSel && busWrite && inDir;
    st.accClr  = busSel && busWrite && (busPage == ACC_CLR);
    st.dirClr  = busSel && busWrite && (busPage == DIR_CLR);
    st.rdEn    = busSel && !busWrite && (inAcc || inDir);
    st.rdDirty = inDir;
    st.wordIdx = inDir ? SLOT_W'(busPage - DIR_LO) : SLOT_W'(busPage - ACC_LO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= busSel && inRange;
  end

  assign busAckN = {2{~ackQ}};

  AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> busAckN == 2'b11); // R9

  AST_ACK_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    busAckN[0] == busAckN[1]); // R8

endmodule

// File: rtl/pageUseData.sv
module pageUseData
  import pageUseTrackerPkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WORD_W  = 16,
  localparam int NWORDS = ENTRIES / WORD_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  trackStrobe_t      st,
  input  logic [IDX_W-1:0]  hitIndex,
  input  logic [WORD_W-1:0] busWData,
  output logic [WORD_W-1:0] busRData
);

  logic [ENTRIES-1:0] accVec, dirVec, accNext, dirNext;
  logic [WORD_W-1:0]  accWordNext [NWORDS];
  logic [WORD_W-1:0]  dirWordNext [NWORDS];
  logic [WORD_W-1:0]  rdWord;

  for (genvar w = 0; w < NWORDS; w++) begin : gWord
    logic accLoad, dirLoad;
    assign accLoad = st.accWr && (st.wordIdx == SLOT_W'(w));
    assign dirLoad = st.dirWr && (st.wordIdx == SLOT_W'(w));

    always_comb begin
      accWordNext[w] = accVec[w*WORD_W +: WORD_W];
      if (st.accClr) accWordNext[w] = '0;
      if (accLoad)   accWordNext[w] = busWData;
      for (int b = 0; b < WORD_W; b++)
        if (st.hwAcc && (hitIndex == IDX_W'(w*WORD_W + b))) accWordNext[w][b] = 1'b1;

      dirWordNext[w] = dirVec[w*WORD_W +: WORD_W];
      if (st.dirClr) dirWordNext[w] = '0;
      if (dirLoad)   dirWordNext[w] = busWData;
      for (int b = 0; b < WORD_W; b++)
        if (st.hwDir && (hitIndex == IDX_W'(w*WORD_W + b))) dirWordNext[w][b] = 1'b1;
    end

    assign accNext[w*WORD_W +: WORD_W] = accWordNext[w];
    assign dirNext[w*WORD_W +: WORD_W] = dirWordNext[w];
  end

  always_comb begin
    rdWord = '0;
    for (int w = 0; w < NWORDS; w++)
      if (st.wordIdx == SLOT_W'(w))
        rdWord = st.rdDirty ? dirVec[w*WORD_W +: WORD_W] : accVec[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accVec   <= '0;
      dirVec   <= '0;
      busRData <= '0;
    end else begin
      accVec   <= accNext;
      dirVec   <= dirNext;
      busRData <= st.rdEn ? rdWord : '0;
    end
  end

  AST_REF_SET: assert property (@(posedge clk) disable iff (!rstN)
    st.hwAcc |=> accVec[$past(hitIndex)]); // R2

  AST_MOD_SET: assert property (@(posedge clk) disable iff (!rstN)
    st.hwDir |=> dirVec[$past(hitIndex)]); // R3

  AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!st.hwAcc && !st.accWr && !st.accClr) |=> $stable(accVec)); // R4

  AST_MOD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!st.hwDir && !st.dirWr && !st.dirClr) |=> $stable(dirVec)); // R4

  AST_REF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (st.accClr && !st.hwAcc && !st.accWr) |=> accVec == '0); // R6

  AST_MOD_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (st.dirClr && !st.hwDir && !st.dirWr) |=> dirVec == '0); // R6

endmodule

// File: rtl/pageUseTracker.sv
module pageUseTracker
  import pageUseTrackerPkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int WORD_W   = 16,
  parameter int ACC_BASE = 8'h80,
  localparam int NWORDS  = ENTRIES / WORD_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hitStrobe,
  input  logic [IDX_W-1:0]  hitIndex,
  input  logic              hitWrite,
  input  logic              mappedUser,
  input  logic              protFault,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [7:0]        busPage,
  input  logic [WORD_W-1:0] busWData,
  output logic [WORD_W-1:0] busRData,
  output logic [1:0]        busAckN
);

  trackStrobe_t st;

  pageUseCtrl #(.NWORDS(NWORDS), .ACC_BASE(ACC_BASE)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hitStrobe(hitStrobe), .hitWrite(hitWrite),
    .mappedUser(mappedUser), .protFault(protFault),
    .busSel(busSel), .busWrite(busWrite), .busPage(busPage),
    .st(st), .busAckN(busAckN)
  );

  pageUseData #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .hitIndex(hitIndex),
    .busWData(busWData), .busRData(busRData)
  );

endmodule

// File: tb/sim_pageUseTracker.sv
module sim_pageUseTracker;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hitStrobe = 0, hitWrite = 0, mappedUser = 0, protFault = 0;
  logic [5:0] hitIndex = '0;
  logic busSel = 0, busWrite = 0;
  logic [7:0] busPage = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic [1:0] busAckN;

  int checks = 0, errors = 0;
  logic [63:0] expAcc = '0, expDir = '0;
  bit done = 0;

  always #2 clk = ~clk;

  pageUseTracker u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hit(input int idx, input bit wr, input bit mu, input bit pf);
    @(negedge clk);
    hitStrobe = 1; hitIndex = 6'(idx); hitWrite = wr; mappedUser = mu; protFault = pf;
    @(negedge clk);
    hitStrobe = 0; hitWrite = 0; mappedUser = 0; protFault = 0;
  endtask

  task automatic busWr(input logic [7:0] pg, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busPage = pg; busWData = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input string req, input logic [7:0] pg, input logic [15:0] exp, input bit expAck);
    @(negedge clk);
    busSel = 1; busWrite = 0; busPage = pg;
    @(negedge clk);
    busSel = 0;
    check(req, {16'h0, busRData}, {16'h0, exp});
    check(req, {30'h0, busAckN}, expAck ? 32'h0 : 32'h3);
    @(negedge clk);
    check(req, {30'h0, busAckN}, 32'h3);
  endtask

  task automatic readAll(input string req);
    for (int w = 0; w < 4; w++) begin
      busRd(req, 8'h80 + 8'(w), expAcc[w*16 +: 16], 1);
      busRd(req, 8'h85 + 8'(w), expDir[w*16 +: 16], 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {30'h0, busAckN}, 32'h3);
    check("R1", {16'h0, busRData}, 32'h0);
    rstN = 1;
    readAll("R1");

    // R4: hits that must be ignored
    for (int i = 0; i < 64; i++) hit(i, 1, (i % 3) == 1, (i % 3) != 2);
    readAll("R4");

    // R2 R3: qualifying hits, every third one writes
    for (int i = 0; i < 64; i++) begin
      hit(i, (i % 3) == 0, 1, 0);
      expAcc[i] = 1;
      if (i % 3 == 0) expDir[i] = 1;
    end
    readAll("R2_R3");

    // R5: walking-one and checkerboard word writes
    for (int w = 0; w < 4; w++) begin
      busWr(8'h80 + 8'(w), 16'h1 << (w * 5));
      expAcc[w*16 +: 16] = 16'h1 << (w * 5);
      busWr(8'h85 + 8'(w), (w % 2) ? 16'hAAAA : 16'h5555);
      expDir[w*16 +: 16] = (w % 2) ? 16'hAAAA : 16'h5555;
    end
    readAll("R5");

    // R6: clear-all pages
    busWr(8'h84, 16'hFFFF); expAcc = '0;
    readAll("R6_ref");
    for (int w = 0; w < 4; w++) begin
      busWr(8'h80 + 8'(w), 16'hF00F); expAcc[w*16 +: 16] = 16'hF00F;
    end
    busWr(8'h89, 16'h0); expDir = '0;
    readAll("R6_mod");

    // R7: hardware set against zeroing word write and clear
    @(negedge clk);
    busSel = 1; busWrite = 1; busPage = 8'h81; busWData = 16'h0;
    hitStrobe = 1; hitIndex = 6'd21; hitWrite = 1; mappedUser = 1; protFault = 0;
    @(negedge clk);
    busSel = 0; busWrite = 0; hitStrobe = 0; hitWrite = 0; mappedUser = 0;
    expAcc[31:16] = 16'h0020; expDir[21] = 1;
    busRd("R7", 8'h81, 16'h0020, 1);
    @(negedge clk);
    busSel = 1; busWrite = 1; busPage = 8'h89;
    hitStrobe = 1; hitIndex = 6'd63; hitWrite = 1; mappedUser = 1;
    @(negedge clk);
    busSel = 0; busWrite = 0; hitStrobe = 0; hitWrite = 0; mappedUser = 0;
    expDir = '0; expDir[63] = 1; expAcc[63] = 1;
    readAll("R7");

    // R8: clear pages read as zero with acknowledge
    busRd("R8", 8'h84, 16'h0, 1);
    busRd("R8", 8'h89, 16'h0, 1);

    // R9: out-of-range pages: no ack, no change
    busRd("R9", 8'h7F, 16'h0, 0);
    busRd("R9", 8'h8A, 16'h0, 0);
    busWr(8'h8A, 16'hFFFF);
    busWr(8'h7F, 16'h0);
    readAll("R9");

    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule